// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block guards a system against runaway software. A counter advances on each cycle where the tick input is high. Software must pulse the clear input before the count reaches the selected interval. If it does not, the block raises a reset request for one clock cycle. The count then starts again from zero, so a system that never services the block keeps getting requests.

A 4-bit control word is loaded through a plain write strobe with data. It reset to all ones, which means the watchdog is unlocked, stopped and set to its longest interval. While unlocked, the stop bit turns the watchdog on and off. Writing the lock bit low starts the watchdog for good. Only the reset input can undo that. No data flows through the block, so every pin is a plain control or status signal with no handshake.

Top module: `wdg_guard`

## Requirements
- R1: After reset the control word is 4'b1111 (bit 3 unlock = 1, bit 2 halt = 1, bits 1:0 span = 11), reset_req is low, and no request is raised while the control word stays unwritten, whatever tick does.
- R2: While unlocked (bit 3 = 1), a control write with bit 2 = 1 stops the watchdog and holds its count at zero, and a write with bit 2 = 0 starts it from zero.
- R3: A control write with bit 3 = 0 starts the watchdog whatever bit 2 holds.
- R4: Once bit 3 is 0, later writes cannot set it back to 1, and bit 2 cannot stop the watchdog, until the reset input is asserted.
- R5: Span code 00, 01, 10 and 11 (bits 1:0) selects an interval of 2^LOG2_T0, 2^LOG2_T1, 2^LOG2_T2 and 2^LOG2_T3 ticks (512, 2048, 16384 and 131072 by default).
- R6: A clear pulse returns the count to zero in the cycle it is sampled. It takes priority over a tick in the same cycle, and no request is raised for that cycle.
- R7: reset_req is high for exactly one cycle, in the cycle after the edge that takes the interval's final tick. Counting then starts over from zero.
- R8: A control write that changes the span code restarts the count from zero.
- R9: The count advances only on edges where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable; one tick per high cycle |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word: [3] unlock, [2] halt, [1:0] span |
| kick | input | 1 | Clear strobe from software |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench reduces the interval parameters so that every span code can be run until it times out. Each run is timed in ticks with tick held high, which separates the four intervals and checks that requests repeat back to back. A second run gives a tick only every third cycle, which shows that the count follows tick and not the clock. Clear pulses are placed mid-interval and on the final tick, and a span change is made mid-count, to show that each one restarts the interval. Lock tests write values that try to unlock and stop the block, and check that the request still arrives at the expected tick.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef struct packed {
    logic       unlock;
    logic       halt;
    logic [1:0] span;
  } wdg_ctrl_t;

  localparam wdg_ctrl_t WDG_CTRL_INIT = 4'b1111;
  localparam int unsigned WDG_SPANS = 4;

  function automatic int unsigned wdg_max4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic [3:0] ctrl_wdata,
  output wdg_ctrl_t  ctrl,
  output logic       active,
  output logic       span_chg
);

  wdg_ctrl_t wr_word;

  assign wr_word = wdg_ctrl_t'(ctrl_wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= WDG_CTRL_INIT;
    end else if (ctrl_we) begin
      // unlock can only fall; a one-way latch until reset
      ctrl.unlock <= ctrl.unlock & wr_word.unlock;
      ctrl.halt   <= wr_word.halt;
      ctrl.span   <= wr_word.span;
    end
  end

  // locked forces run; halt matters only while unlocked
  assign active   = !ctrl.unlock || !ctrl.halt;
  assign span_chg = ctrl_we && (wr_word.span != ctrl.span);

endmodule

// File: rtl/wdg_span_limit.sv
module wdg_span_limit
  import wdg_pkg::*;
#(
  parameter int unsigned LOG2_T0 = 9,
  parameter int unsigned LOG2_T1 = 11,
  parameter int unsigned LOG2_T2 = 14,
  parameter int unsigned LOG2_T3 = 17,
  parameter int unsigned CNT_W   = 17
) (
  input  logic [1:0]       span,
  output logic [CNT_W-1:0] last
);

  localparam int unsigned LOGS [WDG_SPANS] = '{LOG2_T0, LOG2_T1, LOG2_T2, LOG2_T3};

  logic [CNT_W-1:0] tbl [WDG_SPANS];

  // final count value of each interval: 2^LOG2 - 1
  for (genvar i = 0; i < WDG_SPANS; i++) begin : g_tbl
    assign tbl[i] = CNT_W'((64'd1 << LOGS[i]) - 64'd1);
  end

  assign last = tbl[span];

endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] cnt,
  output logic             fire
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!active || restart) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == last) begin
          cnt  <= '0;
          fire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int unsigned LOG2_T0 = 9,
  parameter int unsigned LOG2_T1 = 11,
  parameter int unsigned LOG2_T2 = 14,
  parameter int unsigned LOG2_T3 = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       ctrl_we,
  input  logic [3:0] ctrl_wdata,
  input  logic       kick,
  output logic       reset_req
);

  localparam int unsigned CNT_W = wdg_max4(LOG2_T0, LOG2_T1, LOG2_T2, LOG2_T3);

  wdg_ctrl_t        ctrl;
  logic [3:0]       ctrl_bits;
  logic             active;
  logic             span_chg;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] cnt;

  wdg_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl       (ctrl),
    .active     (active),
    .span_chg   (span_chg)
  );

  wdg_span_limit #(
    .LOG2_T0 (LOG2_T0),
    .LOG2_T1 (LOG2_T1),
    .LOG2_T2 (LOG2_T2),
    .LOG2_T3 (LOG2_T3),
    .CNT_W   (CNT_W)
  ) u_limit (
    .span (ctrl.span),
    .last (last)
  );

  wdg_count #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .restart (kick || span_chg),
    .tick    (tick),
    .last    (last),
    .cnt     (cnt),
    .fire    (reset_req)
  );

  assign ctrl_bits = ctrl;

endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
  parameter int unsigned CNT_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             ctrl_we,
  input logic [3:0]       ctrl_wdata,
  input logic             kick,
  input logic             reset_req,
  input logic [3:0]       ctrl_bits,
  input logic             active,
  input logic [CNT_W-1:0] cnt
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ctrl_bits == 4'b1111) && !reset_req);

  p_stopped_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == '0) && !reset_req);

  p_lock_runs_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !ctrl_wdata[3]) |=> active);

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl_bits[3] |=> !ctrl_bits[3]);

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt == '0) && !reset_req);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (cnt == '0));

  p_pulse_width_r7: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (active && !tick && !kick && !ctrl_we) |=> $stable(cnt) && !reset_req);

endmodule

bind wdg_guard wdg_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .ctrl_we    (ctrl_we),
  .ctrl_wdata (ctrl_wdata),
  .kick       (kick),
  .reset_req  (reset_req),
  .ctrl_bits  (ctrl_bits),
  .active     (active),
  .cnt        (cnt)
);

// File: tb/wdg_guard_bench.sv
module wdg_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int L0 = 4;
  localparam int L1 = 5;
  localparam int L2 = 6;
  localparam int L3 = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [3:0] ctrl_wdata = 4'h0;
  logic       kick = 1'b0;
  logic       reset_req;

  int errs = 0;
  int checks = 0;

  wdg_guard #(
    .LOG2_T0 (L0), .LOG2_T1 (L1), .LOG2_T2 (L2), .LOG2_T3 (L3)
  ) u_wdg_guard (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .kick       (kick),
    .reset_req  (reset_req)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int span_ticks(input int s);
    int lg [4] = '{L0, L1, L2, L3};
    return 1 << lg[s];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b0; kick = 1'b0; ctrl_we = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v; tick = 1'b0;
    step();
    ctrl_we = 1'b0;
  endtask

  // count ticks until reset_req is seen; -1 if it never comes
  task automatic measure(input int period, input int maxt, output int n);
    int c = 0;
    n = 0;
    forever begin
      tick = ((c % period) == 0);
      c++;
      step();
      if (tick) n++;
      if (reset_req) begin tick = 1'b0; return; end
      if (n > maxt) begin n = -1; tick = 1'b0; return; end
    end
  endtask

  task automatic width_check(input string req);
    tick = 1'b0;
    step();
    chk(reset_req == 1'b0, req, reset_req, 0);
  endtask

  task automatic quiet_ticks(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
      if (reset_req) hits++;
    end
    tick = 1'b0;
    chk(hits == 0, req, hits, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(reset_req == 1'b0, "R1", reset_req, 0);
    quiet_ticks(300, "R1");
  endtask

  task automatic t_intervals();
    int n;
    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr({2'b10, 2'(s)});
      measure(1, 4 * span_ticks(s), n);
      chk(n == span_ticks(s), "R5", n, span_ticks(s));
      width_check("R7");
      measure(1, 4 * span_ticks(s), n);
      chk(n == span_ticks(s), "R7", n, span_ticks(s));
    end
  endtask

  task automatic t_stop();
    int n;
    do_reset();
    wr(4'b1000);
    quiet_ticks(10, "R2");
    wr(4'b1100);
    quiet_ticks(200, "R2");
    wr(4'b1000);
    measure(1, 200, n);
    chk(n == span_ticks(0), "R2", n, span_ticks(0));
  endtask

  task automatic t_tick_rate();
    int n;
    do_reset();
    wr(4'b1001);
    measure(3, 200, n);
    chk(n == span_ticks(1), "R9", n, span_ticks(1));
  endtask

  task automatic t_kick();
    int n;
    do_reset();
    wr(4'b1000);
    quiet_ticks(10, "R6");
    kick = 1'b1; tick = 1'b1;
    step();
    kick = 1'b0; tick = 1'b0;
    measure(1, 200, n);
    chk(n == span_ticks(0), "R6", n, span_ticks(0));
    // clear landing on the final tick of an interval
    width_check("R7");
    quiet_ticks(span_ticks(0) - 1, "R6");
    kick = 1'b1; tick = 1'b1;
    step();
    kick = 1'b0; tick = 1'b0;
    chk(reset_req == 1'b0, "R6", reset_req, 0);
    measure(1, 200, n);
    chk(n == span_ticks(0), "R6", n, span_ticks(0));
  endtask

  task automatic t_span_change();
    int n;
    do_reset();
    wr(4'b1001);
    quiet_ticks(20, "R8");
    wr(4'b1000);
    measure(1, 400, n);
    chk(n == span_ticks(0), "R8", n, span_ticks(0));
  endtask

  task automatic t_lock();
    int n;
    do_reset();
    wr(4'b0100);
    measure(1, 400, n);
    chk(n == span_ticks(0), "R3", n, span_ticks(0));
    wr(4'b1100);
    measure(1, 400, n);
    chk(n == span_ticks(0), "R4", n, span_ticks(0));
    wr(4'b1111);
    measure(1, 400, n);
    chk(n == span_ticks(3), "R4", n, span_ticks(3));
    do_reset();
    quiet_ticks(300, "R1");
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_intervals();
    t_stop();
    t_tick_rate();
    t_kick();
    t_span_change();
    t_lock();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule